// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind a two-wire serial protocol controller in a byte-addressed storage device. The controller turns decoded bus events into single-cycle strobes: a start marker, a load of the starting word address, one strobe per received data byte, and a stop marker. The block keeps the bytes of the current write transaction in a 32-entry page buffer. It records which entries were written, and it leaves the storage array untouched until the transaction closes.

When a stop arrives and at least one byte is held, the block starts a self-timed write cycle, provided the write-protect input is low. It copies every written buffer entry into the same page row of the array and raises a busy flag for a fixed number of clock cycles. During that window it ignores all transaction strobes. A restart before the stop, a stop with no data, or a stop with write-protect high ends the transaction with no busy period and no change to the array. A registered read port lets the controller fetch any array byte.

The array holds 2**ADDR_W bytes in pages of 2**PAGE_W bytes. A full-size device uses ADDR_W = 13 (256 pages of 32 bytes). The default elaboration uses a smaller array.

Top module: `pgwr_commit`

## Requirements
- R1: After a synchronous reset, busy_o is low and no transaction is open, so a stop strobe alone does not raise busy_o.
- R2: Data bytes strobed after an address load occupy consecutive addresses starting at the loaded address. After the write cycle, each one reads back at its address.
- R3: After each accepted byte, only the low 5 address bits (the in-page offset) advance, modulo 32. The page bits addr[ADDR_W-1:5] never change, so a transaction that starts at offset 30 writes offsets 30, 31, 0 of the same page.
- R4: When more than 32 bytes arrive in one transaction, the later bytes overwrite the earlier ones at the wrapped offsets. The last byte sent to each offset is the one committed.
- R5: No array location changes before the stop strobe closes the transaction.
- R6: Only offsets written in the current transaction change. All other bytes of the page keep their previous contents.
- R7: A stop that closes a transaction holding at least one byte, with wp_i low, sets busy_o high from the next clock edge for exactly TWR_CYC cycles.
- R8: While busy_o is high, start, address-load, byte and stop strobes are ignored. They neither change the array nor extend or restart the busy period.
- R9: With wp_i high at the stop strobe, nothing is committed and busy_o stays low.
- R10: A start strobe before the stop discards the buffered bytes. No array write and no busy period follow.
- R11: A stop after an address load with no data byte raises no busy period.
- R12: rd_data_o presents the array byte at rd_addr_i one clock after the address is applied. This holds across the full address range, including the last page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-marker strobe from the protocol controller |
| addr_ld_i | input | 1 | Load the starting word address and open a write transaction |
| addr_i | input | ADDR_W | Word address loaded by addr_ld_i |
| byte_wr_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop-marker strobe that closes the transaction |
| wp_i | input | 1 | Write protect; high blocks any commit for the whole array |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Registered read data |
| busy_o | output | 1 | High while the self-timed write cycle runs |

## Verification
The bench builds the block with ADDR_W = 8 and TWR_CYC = 40. That gives an eight-page array, small enough to prefill and check byte by byte, and a busy window short enough to count exactly on every commit. With only eight pages, the last-page case and the in-page wrap from offset 31 to offset 0 come up in a few transactions. A 40-byte burst shows that overwriting after a wrap leaves the final byte for each offset. The short window also leaves room to fire a full rejected transaction inside one busy period and then confirm that the period length did not change.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_FILL = 2'd1,
    SQ_BURN = 2'd2
  } sq_state_t;
endpackage

// File: rtl/pgwr_array.sv
module pgwr_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  // one write port, one registered read port: maps onto a simple dual-port RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgwr_pagebuf.sv
module pgwr_pagebuf #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic [ADDR_W-1:0]        ld_addr,
  input  logic                     push,
  input  logic [7:0]               push_data,
  input  logic [PAGE_W-1:0]        rd_idx,
  output logic [ADDR_W-PAGE_W-1:0] page_o,
  output logic [(1<<PAGE_W)-1:0]   mask_o,
  output logic [7:0]               rd_byte_o
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int ROW_W  = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] ptr_q;
  logic [ROW_W-1:0]  page_q;
  logic [PAGE_N-1:0] mask_q;
  logic [7:0]        slot_w [PAGE_N];

  for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
    logic [7:0] cell_q;
    always_ff @(posedge clk) begin
      if (push && ptr_q == PAGE_W'(g)) cell_q <= push_data;
    end
    assign slot_w[g] = cell_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      page_q <= '0;
      mask_q <= '0;
    end else if (clr) begin
      ptr_q  <= ld_addr[PAGE_W-1:0];
      page_q <= ld_addr[ADDR_W-1:PAGE_W];
      mask_q <= '0;
    end else if (push) begin
      ptr_q         <= ptr_q + 1'b1;
      mask_q[ptr_q] <= 1'b1;
    end
  end

  assign page_o    = page_q;
  assign mask_o    = mask_q;
  assign rd_byte_o = slot_w[rd_idx];

  // R6
  mask_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !clr) |=> mask_q[$past(ptr_q)]);

  // R10
  mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (mask_q == '0));

  // R3
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !clr) |=> (page_q == $past(page_q)));
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
  import pgwr_pkg::*;
#(
  parameter int PAGE_W  = 5,
  parameter int TWR_CYC = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              addr_ld_i,
  input  logic              byte_wr_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              any_i,
  output logic              clr_o,
  output logic              push_o,
  output logic              commit_o,
  output logic [PAGE_W-1:0] idx_o,
  output logic              busy_o
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int CNT_W  = $clog2(TWR_CYC + 1);

  sq_state_t        st_q, st_n;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             open_ok;

  assign open_ok  = (st_q != SQ_BURN);
  assign clr_o    = open_ok && addr_ld_i && !start_i && !stop_i;
  assign push_o   = (st_q == SQ_FILL) && byte_wr_i && !start_i && !stop_i && !addr_ld_i;
  assign idx_o    = cnt_q[PAGE_W-1:0];
  assign commit_o = (st_q == SQ_BURN) && (32'(cnt_q) < PAGE_N);
  assign busy_o   = busy_q;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      SQ_IDLE: if (clr_o) st_n = SQ_FILL;
      SQ_FILL: begin
        if (start_i)     st_n = SQ_IDLE;
        else if (stop_i) st_n = (any_i && !wp_i) ? SQ_BURN : SQ_IDLE;
      end
      SQ_BURN: if (cnt_q == CNT_W'(TWR_CYC - 1)) st_n = SQ_IDLE;
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_IDLE;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_n;
      busy_q <= (st_n == SQ_BURN);
      cnt_q  <= (st_q == SQ_BURN) ? cnt_q + 1'b1 : '0;
    end
  end

  // busy window length counter for checking only
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= busy_q ? run_q + 1'b1 : '0;
  end

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (run_q == (CNT_W+1)'(TWR_CYC)));

  // R9
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == SQ_FILL) && stop_i && !start_i && wp_i) |=> !busy_q);

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == SQ_FILL) && start_i) |=> (!busy_q && st_q == SQ_IDLE));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |=> busy_q);
endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit #(
  parameter int ADDR_W  = 11,
  parameter int PAGE_W  = 5,
  parameter int TWR_CYC = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              addr_ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_wr_i,
  input  logic [7:0]        byte_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int ROW_W  = ADDR_W - PAGE_W;

  logic              clr, push, commit, mem_we;
  logic [PAGE_W-1:0] idx;
  logic [ROW_W-1:0]  page;
  logic [PAGE_N-1:0] mask;
  logic [7:0]        slot_byte;

  pgwr_seq #(.PAGE_W(PAGE_W), .TWR_CYC(TWR_CYC)) u_seq (
    .clk(clk), .rst(rst),
    .start_i(start_i), .addr_ld_i(addr_ld_i), .byte_wr_i(byte_wr_i),
    .stop_i(stop_i), .wp_i(wp_i), .any_i(|mask),
    .clr_o(clr), .push_o(push), .commit_o(commit), .idx_o(idx),
    .busy_o(busy_o)
  );

  pgwr_pagebuf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst(rst), .clr(clr), .ld_addr(addr_i),
    .push(push), .push_data(byte_i), .rd_idx(idx),
    .page_o(page), .mask_o(mask), .rd_byte_o(slot_byte)
  );

  assign mem_we = commit && mask[idx];

  pgwr_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr({page, idx}), .wdata(slot_byte),
    .raddr(rd_addr_i), .rdata(rd_data_o)
  );

  // R5
  write_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy_o);

  // R8
  quiet_push_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !push && !clr);
endmodule

// File: tb/sim_pgwr_commit.sv
module sim_pgwr_commit;
  localparam int AW  = 8;
  localparam int TWR = 40;
  localparam int MN  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, addr_ld_i = 0, byte_wr_i = 0, stop_i = 0, wp_i = 0;
  logic [AW-1:0] addr_i = '0, rd_addr_i = '0;
  logic [7:0] byte_i = '0;
  logic [7:0] rd_data_o;
  logic busy_o;

  always #5 clk = ~clk;

  pgwr_commit #(.ADDR_W(AW), .PAGE_W(5), .TWR_CYC(TWR)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_ld_i(addr_ld_i),
    .addr_i(addr_i), .byte_wr_i(byte_wr_i), .byte_i(byte_i),
    .stop_i(stop_i), .wp_i(wp_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .busy_o(busy_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [MN];

  // table: {start address, byte count, data seed}
  localparam logic [23:0] VEC [6] = '{
    {8'h23, 8'd1,  8'h11},   // R2 single byte
    {8'h5E, 8'd3,  8'h40},   // R3 wrap 30,31,0
    {8'h80, 8'd33, 8'h90},   // R4 overwrite offset 0
    {8'hE7, 8'd5,  8'h05},   // R6 partial page
    {8'hFF, 8'd2,  8'hA0},   // R12 last byte of array, wraps to 0xE0
    {8'h41, 8'd40, 8'h33}    // R4 longer burst
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input int kind, input logic [7:0] v);
    case (kind)
      0: start_i = 1;
      1: begin addr_ld_i = 1; addr_i = v; end
      2: begin byte_wr_i = 1; byte_i = v; end
      default: stop_i = 1;
    endcase
    @(negedge clk);
    start_i = 0; addr_ld_i = 0; byte_wr_i = 0; stop_i = 0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy_o && n < 1000) begin n++; @(negedge clk); end
  endtask

  function automatic logic [7:0] dat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7);
  endfunction

  function automatic logic [7:0] wrap_addr(input logic [7:0] a, input int i);
    return {a[7:5], 5'(a[4:0] + 5'(i))};
  endfunction

  task automatic do_write(input logic [7:0] a, input int n, input logic [7:0] seed,
                          input bit wp, input string tag);
    int bl;
    strobe(0, 0);
    strobe(1, a);
    for (int i = 0; i < n; i++) strobe(2, dat(seed, i));
    wp_i = wp;
    strobe(3, 0);
    wp_i = 0;
    busy_len(bl);
    chk(bl == ((n > 0 && !wp) ? TWR : 0), tag, bl, (n > 0 && !wp) ? TWR : 0);
    if (n > 0 && !wp)
      for (int i = 0; i < n; i++) model[wrap_addr(a, i)] = dat(seed, i);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_addr_i = a;
    @(negedge clk);
    d = rd_data_o;
  endtask

  task automatic check_page(input logic [7:0] a, input string tag);
    logic [7:0] d;
    for (int i = 0; i < 32; i++) begin
      rd({a[7:5], 5'(i)}, d);
      chk(d === model[{a[7:5], 5'(i)}], tag, d, model[{a[7:5], 5'(i)}]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int bl;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state and stray stop
    chk(busy_o == 0, "R1 busy after reset", busy_o, 0);
    strobe(3, 0);
    chk(busy_o == 0, "R1 stop with no transaction", busy_o, 0);

    // R2/R7 prefill every page
    for (int p = 0; p < MN / 32; p++) do_write(8'(p * 32), 32, 8'(p * 16 + 3), 0, "R7 busy length");
    for (int p = 0; p < MN / 32; p++) check_page(8'(p * 32), "R2 prefill readback");

    // table walk
    for (int k = 0; k < 6; k++) begin
      do_write(VEC[k][23:16], int'(VEC[k][15:8]), VEC[k][7:0], 0, "R7 busy length");
      check_page(VEC[k][23:16], "R3 R4 R6 R12 page contents");
    end

    // R5 array unchanged before stop
    strobe(0, 0);
    strobe(1, 8'h20);
    strobe(2, 8'hAA);
    strobe(2, 8'hBB);
    rd(8'h20, d);
    chk(d === model[8'h20], "R5 before stop", d, model[8'h20]);
    strobe(3, 0);
    busy_len(bl);
    chk(bl == TWR, "R7 busy length", bl, TWR);
    model[8'h20] = 8'hAA; model[8'h21] = 8'hBB;
    check_page(8'h20, "R5 after stop");

    // R8 strobes ignored while busy
    strobe(0, 0);
    strobe(1, 8'hC4);
    strobe(2, 8'h5A);
    strobe(3, 0);
    bl = 0;
    chk(busy_o == 1, "R8 busy started", busy_o, 1);
    strobe(0, 0); bl++;
    strobe(1, 8'h62); bl++;
    strobe(2, 8'h77); bl++;
    strobe(2, 8'h78); bl++;
    strobe(3, 0); bl++;
    begin
      int rest;
      busy_len(rest);
      chk(bl + rest == TWR, "R8 busy not extended", bl + rest, TWR);
    end
    model[8'hC4] = 8'h5A;
    repeat (3) @(negedge clk);
    chk(busy_o == 0, "R8 no second busy", busy_o, 0);
    check_page(8'h60, "R8 page untouched");
    check_page(8'hC0, "R8 first commit kept");

    // R9 write protect
    do_write(8'h10, 4, 8'hE1, 1, "R9 no busy under wp");
    check_page(8'h00, "R9 array unchanged");

    // R10 restart discards
    strobe(0, 0);
    strobe(1, 8'h48);
    strobe(2, 8'h01);
    strobe(2, 8'h02);
    strobe(0, 0);
    strobe(3, 0);
    chk(busy_o == 0, "R10 no busy after abort", busy_o, 0);
    check_page(8'h40, "R10 array unchanged");

    // R11 address only
    do_write(8'hA3, 0, 8'h00, 0, "R11 no busy without data");
    check_page(8'hA0, "R11 array unchanged");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule